// File: doc/BRIEF.md
# Flash Command Write Sequencer

This block sits between a flash management client and a parallel NOR flash that uses a 32-bit write-only bus. The client asks for one of three operations: program one word, erase the whole chip, or erase one sector. The client gives a target address and a data word with the request. The block then drives the fixed unlock and command writes that the flash expects, one bus write at a time. Each write is held on the bus until the memory acknowledges it. The write sequence is never broken up.

While a sequence is running, the block reports busy and holds off any read request from the rest of the system. A read placed between two writes would abort the flash command. When the last write is acknowledged, the block pulses done for one clock and is ready for the next request. A request that arrives while a sequence is running is dropped, and so is a request with an unknown command code. In both cases the block flags the drop with a one-clock reject pulse.

Top module: `flash_cmd_seq`

## Requirements
- R1: Command code 00 (program) produces exactly four bus writes, in this order:
  1. 1FC0_2AA8h / AAAA_AAAAh
  2. 1FC0_1554h / 5555_5555h
  3. 1FC0_2AA8h / A0A0_A0A0h
  4. the request address / the request data
- R2: Command code 01 (chip erase) produces exactly six bus writes, in this order:
  1. 1FC0_2AA8h / AAAA_AAAAh
  2. 1FC0_1554h / 5555_5555h
  3. 1FC0_2AA8h / 8080_8080h
  4. 1FC0_2AA8h / AAAA_AAAAh
  5. 1FC0_1554h / 5555_5555h
  6. 1FC0_2AA8h / 1010_1010h
- R3: Command code 10 (sector erase) produces the same first five writes as chip erase. Its sixth write puts 3030_3030h at the request address.
- R4: While the write strobe is high and the acknowledge is low, the write address, the write data and the strobe all stay unchanged.
- R5: An accepted request raises busy and the write strobe in the cycle after acceptance. Both stay high until the final acknowledge. The block moves to the next write only on a cycle where the acknowledge is sampled high.
- R6: One cycle after the final acknowledge, done is high for exactly one cycle, and busy and the strobe are both low.
- R7: A request made while busy is ignored: the running sequence continues unchanged, and reject is high for exactly one cycle after the request.
- R8: A request with code 11 is never accepted. Reject pulses in the next cycle, and busy stays low.
- R9: The read stall output equals the read request while busy, and is low whenever the block is idle.
- R10: A synchronous active-high reset returns the block to idle. After reset, the strobe, busy, done, reject and read stall are all low, even when reset arrives in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request strobe for one command |
| reqCmd | input | 2 | Command code: 00 program, 01 chip erase, 10 sector erase, 11 invalid |
| reqAddr | input | 32 | Target address for program or sector erase |
| reqData | input | 32 | Word to program |
| busWrAddr | output | 32 | Bus write address |
| busWrData | output | 32 | Bus write data |
| busWrStb | output | 1 | Bus write strobe |
| busWrAck | input | 1 | Bus write acknowledge |
| rdReq | input | 1 | Read request from the system |
| rdStall | output | 1 | Read request is being held off |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a sequence completes |
| reject | output | 1 | One-cycle pulse when a request is dropped |

## Verification
Busy and the strobe are due one clock after the accepting edge. A new address and data pair is due one clock after each acknowledged edge. Done and reject are due one clock after the edge that caused them. The read stall follows the read request in the same cycle.

The bench drives all inputs and samples all outputs on the falling edge, so each registered result is checked exactly half a clock after the edge that produced it. The acknowledge responder inserts 0 to 3 wait cycles before each acknowledge. At each acknowledge it compares the bus pair with the value first seen when the strobe rose, and with the next item in the scoreboard queue.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    CMD_PROG = 2'b00,
    CMD_CHIP = 2'b01,
    CMD_SECT = 2'b10,
    CMD_BAD  = 2'b11
  } flashCmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch request, restart at first write
    logic advance;  // current write acknowledged
  } seqCtl_t;

  localparam int STEP_W = 3;
  localparam int PROG_LAST = 3;
  localparam int ERASE_LAST = 5;

endpackage

// File: rtl/flash_seq_dpath.sv
module flash_seq_dpath
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] UNLOCK_A = 32'h1FC0_2AA8,
  parameter logic [ADDR_W-1:0] UNLOCK_B = 32'h1FC0_1554
) (
  input  logic              clk,
  input  logic              rst,
  input  seqCtl_t           ctl,
  input  logic [1:0]        cmdIn,
  input  logic [ADDR_W-1:0] tgtAddrIn,
  input  logic [DATA_W-1:0] tgtDataIn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              lastStep
);

  localparam int NBYTES = DATA_W / 8;
  localparam logic [DATA_W-1:0] PAT_AA = {NBYTES{8'hAA}};
  localparam logic [DATA_W-1:0] PAT_55 = {NBYTES{8'h55}};
  localparam logic [DATA_W-1:0] PAT_A0 = {NBYTES{8'hA0}};
  localparam logic [DATA_W-1:0] PAT_80 = {NBYTES{8'h80}};
  localparam logic [DATA_W-1:0] PAT_10 = {NBYTES{8'h10}};
  localparam logic [DATA_W-1:0] PAT_30 = {NBYTES{8'h30}};

  logic [STEP_W-1:0] step;
  flashCmd_e         cmdQ;
  logic [ADDR_W-1:0] tgtAddrQ;
  logic [DATA_W-1:0] tgtDataQ;

  assign lastStep = (cmdQ == CMD_PROG) ? (step == STEP_W'(PROG_LAST))
                                       : (step == STEP_W'(ERASE_LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      step     <= '0;
      cmdQ     <= CMD_PROG;
      tgtAddrQ <= '0;
      tgtDataQ <= '0;
    end else if (ctl.load) begin
      step     <= '0;
      cmdQ     <= flashCmd_e'(cmdIn);
      tgtAddrQ <= tgtAddrIn;
      tgtDataQ <= tgtDataIn;
    end else if (ctl.advance) begin
      step <= lastStep ? '0 : step + 1'b1;
    end
  end

  always_comb begin
    wrAddr = UNLOCK_A;
    wrData = PAT_AA;
    unique case (step)
      3'd0: begin wrAddr = UNLOCK_A; wrData = PAT_AA; end
      3'd1: begin wrAddr = UNLOCK_B; wrData = PAT_55; end
      3'd2: begin
        wrAddr = UNLOCK_A;
        wrData = (cmdQ == CMD_PROG) ? PAT_A0 : PAT_80;
      end
      3'd3: begin
        wrAddr = (cmdQ == CMD_PROG) ? tgtAddrQ : UNLOCK_A;
        wrData = (cmdQ == CMD_PROG) ? tgtDataQ : PAT_AA;
      end
      3'd4: begin wrAddr = UNLOCK_B; wrData = PAT_55; end
      3'd5: begin
        wrAddr = (cmdQ == CMD_SECT) ? tgtAddrQ : UNLOCK_A;
        wrData = (cmdQ == CMD_SECT) ? PAT_30 : PAT_10;
      end
      default: begin wrAddr = '0; wrData = '0; end
    endcase
  end

  // step never passes the last write of the latched command (R1, R2, R3)
  p_step_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (step <= STEP_W'(ERASE_LAST)) && ((cmdQ != CMD_PROG) || (step <= STEP_W'(PROG_LAST))));

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic [1:0] reqCmd,
  input  logic       wrAck,
  input  logic       lastStep,
  output seqCtl_t    ctl,
  output logic       busy,
  output logic       wrStb,
  output logic       done,
  output logic       reject
);

  typedef enum logic {S_IDLE, S_WRITE} state_e;
  state_e state;
  logic   accept;

  assign busy   = (state == S_WRITE);
  assign wrStb  = busy;
  assign accept = !busy && reqValid && (flashCmd_e'(reqCmd) != CMD_BAD);

  always_comb begin
    ctl.load    = accept;
    ctl.advance = busy && wrAck;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      done   <= 1'b0;
      reject <= 1'b0;
    end else begin
      done   <= busy && wrAck && lastStep;
      reject <= reqValid && !accept;
      unique case (state)
        S_IDLE:  if (accept) state <= S_WRITE;
        S_WRITE: if (wrAck && lastStep) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !wrStb));
  p_busy_reject_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && reqValid) |=> reject);
  p_bad_code_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && reqValid && reqCmd == 2'b11) |=> (reject && !busy));
  p_accept_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy && reqValid && reqCmd != 2'b11) |=> (busy && wrStb && !reject));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] UNLOCK_A = 32'h1FC0_2AA8,
  parameter logic [ADDR_W-1:0] UNLOCK_B = 32'h1FC0_1554
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [1:0]        reqCmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic [ADDR_W-1:0] busWrAddr,
  output logic [DATA_W-1:0] busWrData,
  output logic              busWrStb,
  input  logic              busWrAck,
  input  logic              rdReq,
  output logic              rdStall,
  output logic              busy,
  output logic              done,
  output logic              reject
);

  seqCtl_t ctl;
  logic    lastStep;

  flash_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqCmd(reqCmd),
    .wrAck(busWrAck), .lastStep(lastStep), .ctl(ctl), .busy(busy),
    .wrStb(busWrStb), .done(done), .reject(reject)
  );

  flash_seq_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)
  ) u_dpath (
    .clk(clk), .rst(rst), .ctl(ctl), .cmdIn(reqCmd), .tgtAddrIn(reqAddr),
    .tgtDataIn(reqData), .wrAddr(busWrAddr), .wrData(busWrData),
    .lastStep(lastStep)
  );

  assign rdStall = rdReq && busy;

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (busWrStb && !busWrAck) |=> (busWrStb && $stable(busWrAddr) && $stable(busWrData)));
  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (rdReq && busWrStb) |-> rdStall);
  p_reset_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busWrStb && !busy && !done && !reject));

endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
  import flash_seq_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [1:0]  reqCmd = 2'b00;
  logic [31:0] reqAddr = '0, reqData = '0;
  logic [31:0] busWrAddr, busWrData;
  logic        busWrStb;
  logic        busWrAck = 1'b0;
  logic        rdReq = 1'b0;
  logic        rdStall, busy, done, reject;

  always #5 clk = ~clk;

  flash_cmd_seq u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqCmd(reqCmd),
    .reqAddr(reqAddr), .reqData(reqData), .busWrAddr(busWrAddr),
    .busWrData(busWrData), .busWrStb(busWrStb), .busWrAck(busWrAck),
    .rdReq(rdReq), .rdStall(rdStall), .busy(busy), .done(done),
    .reject(reject)
  );

  typedef struct { logic [31:0] a; logic [31:0] d; } wr_t;
  wr_t   sbQ[$];
  int    nChecks = 0, nFails = 0;
  int    waitTarget = 0;
  int    doneCount = 0;
  bit    sbOff = 1'b0;
  string curTag = "R1";

  localparam logic [31:0] UA = 32'h1FC0_2AA8;
  localparam logic [31:0] UB = 32'h1FC0_1554;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] a, input logic [31:0] d);
    wr_t e;
    e.a = a; e.d = d;
    sbQ.push_back(e);
  endtask

  // monitor and acknowledge responder
  initial begin
    int cnt = 0;
    logic [31:0] firstA = '0, firstD = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        busWrAck = 1'b0; cnt = 0;
      end else if (busWrAck) begin
        busWrAck = 1'b0; cnt = 0;
      end else if (busWrStb) begin
        if (cnt == 0) begin firstA = busWrAddr; firstD = busWrData; end
        if (cnt >= waitTarget) begin
          check(busWrAddr == firstA && busWrData == firstD, "R4",
                "pair moved while waiting", busWrAddr, firstA);
          if (!sbOff) begin
            if (sbQ.size() == 0)
              check(1'b0, curTag, "unexpected write", busWrAddr, 32'h0);
            else begin
              wr_t e;
              e = sbQ.pop_front();
              check(busWrAddr == e.a, curTag, "write address", busWrAddr, e.a);
              check(busWrData == e.d, curTag, "write data", busWrData, e.d);
            end
          end
          busWrAck = 1'b1;
        end else cnt++;
      end
      if (done && !rst) begin
        doneCount++;
        check(sbQ.size() == 0, "R6", "writes missing at done", sbQ.size(), 0);
        check(!busy && !busWrStb, "R6", "busy/strobe at done",
              {30'd0, busy, busWrStb}, 32'd0);
      end
    end
  end

  task automatic runCmd(input logic [1:0] cmd, input logic [31:0] a,
                        input logic [31:0] d, input int wt, input string tag,
                        input bit intrude);
    int d0;
    push(UA, 32'hAAAA_AAAA);
    push(UB, 32'h5555_5555);
    if (cmd == 2'b00) begin
      push(UA, 32'hA0A0_A0A0);
      push(a, d);
    end else begin
      push(UA, 32'h8080_8080);
      push(UA, 32'hAAAA_AAAA);
      push(UB, 32'h5555_5555);
      if (cmd == 2'b10) push(a, 32'h3030_3030);
      else push(UA, 32'h1010_1010);
    end
    waitTarget = wt; curTag = tag; d0 = doneCount;
    @(negedge clk);
    reqValid = 1'b1; reqCmd = cmd; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, "R5", "busy after accept", {31'd0, busy}, 32'd1);
    check(busWrStb == 1'b1, "R5", "strobe after accept", {31'd0, busWrStb}, 32'd1);
    rdReq = 1'b1; #1;
    check(rdStall == 1'b1, "R9", "stall while busy", {31'd0, rdStall}, 32'd1);
    rdReq = 1'b0;
    if (intrude) begin
      @(negedge clk);
      check(busy == 1'b1, "R7", "still busy before intrusion", {31'd0, busy}, 32'd1);
      reqValid = 1'b1; reqCmd = 2'b10; reqAddr = 32'hDEAD_0000; reqData = 32'hFFFF_FFFF;
      @(negedge clk);
      reqValid = 1'b0;
      check(reject == 1'b1, "R7", "reject pulse", {31'd0, reject}, 32'd1);
      @(negedge clk);
      check(reject == 1'b0, "R7", "reject one cycle", {31'd0, reject}, 32'd0);
    end
    while (doneCount == d0) @(negedge clk);
    @(negedge clk);
    check(done == 1'b0, "R6", "done one cycle", {31'd0, done}, 32'd0);
    rdReq = 1'b1; #1;
    check(rdStall == 1'b0, "R9", "no stall when idle", {31'd0, rdStall}, 32'd0);
    rdReq = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !busWrStb && !done && !reject, "R10", "reset state",
          {28'd0, busy, busWrStb, done, reject}, 32'd0);
    rdReq = 1'b1; #1;
    check(rdStall == 1'b0, "R10", "stall in reset", {31'd0, rdStall}, 32'd0);
    rdReq = 1'b0;
    rst = 1'b0;

    runCmd(2'b00, 32'h1FC1_0040, 32'h1234_5678, 0, "R1", 1'b0);
    runCmd(2'b01, 32'h0000_0000, 32'h0000_0000, 1, "R2", 1'b0);
    runCmd(2'b10, 32'h1FC2_0000, 32'hCAFE_F00D, 2, "R3", 1'b0);
    runCmd(2'b00, 32'h1FC3_0100, 32'h0BAD_BEEF, 3, "R7", 1'b1);

    // code 11 rejected (R8)
    @(negedge clk);
    reqValid = 1'b1; reqCmd = 2'b11;
    @(negedge clk);
    reqValid = 1'b0;
    check(reject == 1'b1, "R8", "reject on code 11", {31'd0, reject}, 32'd1);
    check(busy == 1'b0, "R8", "not busy on code 11", {31'd0, busy}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!busy && !busWrStb, "R8", "stays idle", {30'd0, busy, busWrStb}, 32'd0);
    end

    // reset in the middle of a chip erase (R10)
    sbOff = 1'b1; waitTarget = 1;
    @(negedge clk);
    reqValid = 1'b1; reqCmd = 2'b01;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rdReq = 1'b1; #1;
    check(!busy && !busWrStb && !rdStall, "R10", "mid-sequence reset",
          {29'd0, busy, busWrStb, rdStall}, 32'd0);
    rdReq = 1'b0;
    sbQ.delete();
    @(negedge clk);
    sbOff = 1'b0;

    runCmd(2'b00, 32'h1FC0_8000, 32'h5A5A_A5A5, 1, "R5", 1'b0);

    summary();
    $finish;
  end

endmodule